// File: doc/BRIEF.md
# Fragmented UDP Receive Checksum Engine

This block sits on the receive path after header parsing. It takes the IP payload of each received frame as a stream of beats, several bytes wide. Alongside the stream it takes the parsed header fields: the layer-3 kind, whether an IPv6 fragment header was seen, the IPv4 fragment offset and more-fragments flag, the transport protocol, the UDP checksum field, the IPv4 identification and an externally computed flow hash. These side fields are sampled on the start-of-frame beat.

The block keeps a 16-bit one's complement sum over the payload bytes. One cycle after the last beat, it presents the descriptor status in a single-cycle valid strobe:

- a 32-bit descriptor word, which holds either the flow hash or the IPv4 identification together with the fragment checksum;
- a UDP-valid flag;
- a UDP-checksum flag;
- an L4-checksum flag.

The sum is reported raw and unadjusted for each fragment. Software can add the reported sums of all fragments of a datagram and finish the UDP check itself.

Fragment reporting is active only when the hash-select configuration bit is clear and the payload-checksum enable bit is set. The configuration bits are sampled on the last beat.

Top module: `rx_frag_csum`

## Requirements
- R1: The descriptor word is the flow hash whenever cfg_hash_sel is 1 or cfg_pay_csum_en is 0. Otherwise it is {ip_id[15:0], checksum[15:0]}, with the identification in bits 31:16.
- R2: For a frame whose layer-3 kind is not IPv4 (hdr_l3 code 0 = other, 2 = IPv6), the checksum half is 0 and UDP-valid is 0. UDP-checksum/L4-checksum is 0/1 for IPv6 with hdr_v6_frag = 0 and protocol 6. It is 0/0 in every other non-IPv4 case.
- R3: For an IPv4 frame (hdr_l3 code 1) with offset 0 and more-fragments 0, the checksum half is 0 and UDP-valid is 0. UDP-checksum/L4-checksum is 1/1 for protocol 17, 0/1 for protocol 6 and 0/0 for any other protocol. This holds in every configuration.
- R4: In fragment mode, an IPv4 fragment with a non-zero offset reports the payload sum, UDP-valid 0 and UDP-checksum/L4-checksum 1/0.
- R5: In fragment mode, an IPv4 fragment with offset 0 and more-fragments 1 reports the payload sum and UDP-checksum/L4-checksum 1/0. UDP-valid is 1 only when the protocol is 17 and the UDP checksum field is non-zero.
- R6: Payload bytes pair big-endian into 16-bit words, the first byte forming the upper half. Each add folds its end-around carry. An odd trailing byte is padded with a zero low byte. An empty payload sums to 0.
- R7: Summing the reported checksums of all fragments of a datagram gives the same result as summing the whole payload at once. A datagram whose payload sum is 0xFFFF therefore yields 0xFFFF.
- R8: out_valid is 1 in exactly the cycle after each last beat, including last beats in consecutive cycles, and 0 otherwise.
- R9: While reset is asserted, out_valid, the descriptor word and all flags are 0.
- R10: Outside fragment mode, an IPv4 fragment reports UDP-valid 0 and UDP-checksum/L4-checksum 0/0.
- R11: Header fields and the hash are taken from the start-of-frame beat. Changes on later beats have no effect, and a new start-of-frame beat discards any partial sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hash_sel | input | 1 | 1 selects the flow hash for the descriptor word |
| cfg_pay_csum_en | input | 1 | Enables payload checksum reporting |
| in_valid | input | 1 | Payload beat present |
| in_sof | input | 1 | First beat of a frame |
| in_eof | input | 1 | Last beat of a frame |
| in_data | input | 8*BEAT_BYTES | Payload bytes, first byte in the top bits |
| in_nbytes | input | CNT_W | Valid bytes on the last beat (0..BEAT_BYTES) |
| hdr_l3 | input | 2 | Layer-3 kind: 0 other, 1 IPv4, 2 IPv6 |
| hdr_v6_frag | input | 1 | IPv6 fragment header present |
| hdr_frag_off | input | 13 | IPv4 fragment offset |
| hdr_more_frag | input | 1 | IPv4 more-fragments flag |
| hdr_proto | input | 8 | Transport protocol number |
| hdr_udp_csum | input | 16 | UDP header checksum field |
| hdr_ip_id | input | 16 | IPv4 identification |
| hash_in | input | 32 | Externally computed flow hash |
| out_valid | output | 1 | Status strobe |
| out_desc_word | output | 32 | Hash or {identification, checksum} |
| out_udpv | output | 1 | UDP-valid flag |
| out_udpcs | output | 1 | UDP-checksum flag |
| out_l4cs | output | 1 | L4-checksum flag |

## Verification
The hardest situations to reach are those where the partial last beat and the end-around carry meet. These are odd lengths that leave one byte of a word dangling, and payloads of all-ones bytes whose every add carries out. They also include a combined sum across two fragments that must land exactly on 0xFFFF. The bench generates the payload bytes and computes each expected sum byte by byte, independent of the beat width. For the two-fragment case it forces the final word of the second fragment to the complement of everything before it. Header fields are scrambled after every start-of-frame beat, so any late sampling shows up in the flags.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;

   localparam logic [7:0] PROTO_TCP = 8'd6;
   localparam logic [7:0] PROTO_UDP = 8'd17;

   typedef enum logic [1:0] {
      L3_OTHER = 2'd0,
      L3_IPV4  = 2'd1,
      L3_IPV6  = 2'd2
   } l3_kind_e;

   typedef struct packed {
      logic [1:0]  l3;
      logic        v6_frag;
      logic [12:0] frag_off;
      logic        more_frag;
      logic [7:0]  proto;
      logic [15:0] udp_csum;
      logic [15:0] ip_id;
      logic [31:0] hash;
   } hdr_t;

   typedef struct packed {
      logic udpv;
      logic udpcs;
      logic l4cs;
      logic keep_sum;
   } stat_t;

   // 16-bit one's complement add with end-around carry folded in
   function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[15:0] + {15'd0, s[16]};
   endfunction

endpackage

// File: rtl/rxcs_sum_acc.sv
module rxcs_sum_acc
   import rxcs_pkg::*;
#(
   parameter int BEAT_BYTES = 4,
   localparam int DATA_W = 8 * BEAT_BYTES,
   localparam int CNT_W  = $clog2(BEAT_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CNT_W-1:0]  in_nbytes,
   output logic [15:0]       sum_final
);

   initial begin
      a_cfg_beat_bytes: assert (BEAT_BYTES == 1 || (BEAT_BYTES % 2 == 0 && BEAT_BYTES <= 64))
         else $error("BEAT_BYTES must be 1 or an even count up to 64");
   end

   logic [15:0] acc_q;
   logic [15:0] base_acc;

   assign base_acc = in_sof ? 16'd0 : acc_q;

   generate
      if (BEAT_BYTES == 1) begin : g_byte
         logic       have_hi_q;
         logic [7:0] hi_q;
         logic       base_have;
         logic [15:0] paired;

         assign base_have = in_sof ? 1'b0 : have_hi_q;
         assign paired    = oc_add(base_acc, {hi_q, in_data});

         always_comb begin
            if (in_eof && in_nbytes == '0) begin
               sum_final = base_have ? oc_add(base_acc, {hi_q, 8'h00}) : base_acc;
            end else if (base_have) begin
               sum_final = paired;
            end else begin
               sum_final = oc_add(base_acc, {in_data, 8'h00});
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q     <= '0;
               hi_q      <= '0;
               have_hi_q <= 1'b0;
            end else if (in_valid) begin
               if (in_eof) begin
                  acc_q     <= '0;
                  have_hi_q <= 1'b0;
               end else if (base_have) begin
                  acc_q     <= paired;
                  have_hi_q <= 1'b0;
               end else begin
                  acc_q     <= base_acc;
                  hi_q      <= in_data;
                  have_hi_q <= 1'b1;
               end
            end
         end
      end else begin : g_word
         localparam int WORDS = BEAT_BYTES / 2;
         logic [DATA_W-1:0] masked;
         logic [15:0]       partial;

         always_comb begin
            for (int k = 0; k < BEAT_BYTES; k++) begin
               if (!in_eof || CNT_W'(k) < in_nbytes) begin
                  masked[DATA_W-1-8*k -: 8] = in_data[DATA_W-1-8*k -: 8];
               end else begin
                  masked[DATA_W-1-8*k -: 8] = 8'h00;
               end
            end
            partial = 16'd0;
            for (int j = 0; j < WORDS; j++) begin
               partial = oc_add(partial, masked[DATA_W-1-16*j -: 16]);
            end
         end

         assign sum_final = oc_add(base_acc, partial);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (in_valid) begin
               acc_q <= in_eof ? 16'd0 : sum_final;
            end
         end
      end
   endgenerate

   // R6: the last beat never claims more bytes than the beat carries
   a_r6_nbytes_range: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eof) |-> (in_nbytes <= CNT_W'(BEAT_BYTES)));

endmodule

// File: rtl/rxcs_classify.sv
module rxcs_classify
   import rxcs_pkg::*;
(
   input  hdr_t  hdr,
   input  logic  frag_mode,
   output stat_t stat
);

   logic is_frag;
   logic is_first;
   logic is_udp;
   logic is_tcp;

   assign is_frag  = (hdr.frag_off != 13'd0) || hdr.more_frag;
   assign is_first = (hdr.frag_off == 13'd0) && hdr.more_frag;
   assign is_udp   = (hdr.proto == PROTO_UDP);
   assign is_tcp   = (hdr.proto == PROTO_TCP);

   always_comb begin
      stat = '0;
      case (l3_kind_e'(hdr.l3))
         L3_IPV4: begin
            if (!is_frag) begin
               stat.udpcs = is_udp;
               stat.l4cs  = is_udp || is_tcp;
            end else if (frag_mode) begin
               stat.udpcs    = 1'b1;
               stat.keep_sum = 1'b1;
               stat.udpv     = is_first && is_udp && (hdr.udp_csum != 16'd0);
            end
         end
         L3_IPV6: begin
            stat.l4cs = !hdr.v6_frag && is_tcp;
         end
         default: begin
            stat = '0;
         end
      endcase
   end

endmodule

// File: rtl/rxcs_status_reg.sv
module rxcs_status_reg
   import rxcs_pkg::*;
#(
   parameter int WORD_W = 32,
   localparam int HALF_W = WORD_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              frag_mode,
   input  stat_t             stat,
   input  logic [15:0]       sum,
   input  logic [HALF_W-1:0] ip_id,
   input  logic [WORD_W-1:0] hash,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_desc_word,
   output logic              out_udpv,
   output logic              out_udpcs,
   output logic              out_l4cs
);

   initial begin
      a_cfg_word_w: assert (WORD_W == 32) else $error("WORD_W must be 32");
   end

   logic [WORD_W-1:0] word_d;

   assign word_d = frag_mode ? {ip_id, (stat.keep_sum ? sum : 16'd0)} : hash;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid     <= 1'b0;
         out_desc_word <= '0;
         out_udpv      <= 1'b0;
         out_udpcs     <= 1'b0;
         out_l4cs      <= 1'b0;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_desc_word <= word_d;
            out_udpv      <= stat.udpv;
            out_udpcs     <= stat.udpcs;
            out_l4cs      <= stat.l4cs;
         end
      end
   end

   // R8: strobe follows a last beat by exactly one cycle
   a_r8_valid_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid);
   a_r8_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> !out_valid);
   // R1: the hash is passed through untouched outside fragment mode
   a_r1_hash_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !frag_mode) |=> (out_desc_word == $past(hash)));
   // R5: UDP-valid only ever comes with the fragment flag pattern
   a_r5_udpv_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_udpv) |-> (out_udpcs && !out_l4cs));

endmodule

// File: rtl/rx_frag_csum.sv
module rx_frag_csum
   import rxcs_pkg::*;
#(
   parameter int BEAT_BYTES = 4,
   localparam int DATA_W = 8 * BEAT_BYTES,
   localparam int CNT_W  = $clog2(BEAT_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_hash_sel,
   input  logic              cfg_pay_csum_en,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CNT_W-1:0]  in_nbytes,
   input  logic [1:0]        hdr_l3,
   input  logic              hdr_v6_frag,
   input  logic [12:0]       hdr_frag_off,
   input  logic              hdr_more_frag,
   input  logic [7:0]        hdr_proto,
   input  logic [15:0]       hdr_udp_csum,
   input  logic [15:0]       hdr_ip_id,
   input  logic [31:0]       hash_in,
   output logic              out_valid,
   output logic [31:0]       out_desc_word,
   output logic              out_udpv,
   output logic              out_udpcs,
   output logic              out_l4cs
);

   hdr_t        hdr_live;
   hdr_t        hdr_q;
   hdr_t        hdr_eff;
   stat_t       stat;
   logic [15:0] sum_final;
   logic        frag_mode;
   logic        fire;

   assign hdr_live = '{l3: hdr_l3, v6_frag: hdr_v6_frag, frag_off: hdr_frag_off,
                       more_frag: hdr_more_frag, proto: hdr_proto,
                       udp_csum: hdr_udp_csum, ip_id: hdr_ip_id, hash: hash_in};
   assign hdr_eff   = in_sof ? hdr_live : hdr_q;
   assign frag_mode = !cfg_hash_sel && cfg_pay_csum_en;
   assign fire      = in_valid && in_eof;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hdr_q <= '0;
      end else if (in_valid && in_sof) begin
         hdr_q <= hdr_live;
      end
   end

   rxcs_sum_acc #(.BEAT_BYTES(BEAT_BYTES)) acc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .in_data   (in_data),
      .in_nbytes (in_nbytes),
      .sum_final (sum_final)
   );

   rxcs_classify cls_i (
      .hdr       (hdr_eff),
      .frag_mode (frag_mode),
      .stat      (stat)
   );

   rxcs_status_reg #(.WORD_W(32)) st_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .fire          (fire),
      .frag_mode     (frag_mode),
      .stat          (stat),
      .sum           (sum_final),
      .ip_id         (hdr_eff.ip_id),
      .hash          (hdr_eff.hash),
      .out_valid     (out_valid),
      .out_desc_word (out_desc_word),
      .out_udpv      (out_udpv),
      .out_udpcs     (out_udpcs),
      .out_l4cs      (out_l4cs)
   );

   // R3 / R4: UDP-valid and L4-checksum never appear together
   a_r3_udpv_l4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_udpv && out_l4cs));
   // R2: a non-IPv4 frame never raises the UDP-checksum flag
   a_r2_nonv4_no_udpcs: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && hdr_eff.l3 != L3_IPV4) |=> !out_udpcs);

endmodule

// File: tb/rx_frag_csum_tb_top.sv
module rx_frag_csum_tb_top;

   localparam int BB = 4;
   localparam int CW = $clog2(BB + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_hash_sel = 1'b0;
   logic          cfg_pay_csum_en = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_sof = 1'b0;
   logic          in_eof = 1'b0;
   logic [8*BB-1:0] in_data = '0;
   logic [CW-1:0] in_nbytes = '0;
   logic [1:0]    hdr_l3 = '0;
   logic          hdr_v6_frag = 1'b0;
   logic [12:0]   hdr_frag_off = '0;
   logic          hdr_more_frag = 1'b0;
   logic [7:0]    hdr_proto = '0;
   logic [15:0]   hdr_udp_csum = '0;
   logic [15:0]   hdr_ip_id = '0;
   logic [31:0]   hash_in = '0;
   logic          out_valid;
   logic [31:0]   out_desc_word;
   logic          out_udpv;
   logic          out_udpcs;
   logic          out_l4cs;

   always #5 clk = ~clk;

   rx_frag_csum #(.BEAT_BYTES(BB)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_hash_sel(cfg_hash_sel),
      .cfg_pay_csum_en(cfg_pay_csum_en), .in_valid(in_valid), .in_sof(in_sof),
      .in_eof(in_eof), .in_data(in_data), .in_nbytes(in_nbytes),
      .hdr_l3(hdr_l3), .hdr_v6_frag(hdr_v6_frag), .hdr_frag_off(hdr_frag_off),
      .hdr_more_frag(hdr_more_frag), .hdr_proto(hdr_proto),
      .hdr_udp_csum(hdr_udp_csum), .hdr_ip_id(hdr_ip_id), .hash_in(hash_in),
      .out_valid(out_valid), .out_desc_word(out_desc_word), .out_udpv(out_udpv),
      .out_udpcs(out_udpcs), .out_l4cs(out_l4cs)
   );

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b);
      logic [16:0] s;
      s = {1'b0, a} + {1'b0, b};
      if (s[16]) s = s + 17'd1;
      return s[15:0];
   endfunction

   logic [7:0] pay [0:255];

   function automatic logic [15:0] ref_sum(input int len);
      logic [15:0] s = 16'd0;
      for (int i = 0; i < len; i += 2) begin
         s = ref_add(s, {pay[i], (i + 1 < len) ? pay[i+1] : 8'h00});
      end
      return s;
   endfunction

   task automatic fill(input int len, input logic [7:0] seed);
      for (int i = 0; i < len; i++) begin
         pay[i] = (seed == 8'hFF) ? 8'hFF : 8'(seed * 8'd29 + i * 17 + 8'h5B);
      end
   endtask

   // header values presented on the sof beat (scrambled afterwards, R11)
   logic [1:0]  t_l3;
   logic        t_v6f;
   logic [12:0] t_off;
   logic        t_mf;
   logic [7:0]  t_proto;
   logic [15:0] t_ucs;
   logic [15:0] t_id;
   logic [31:0] t_hash;

   task automatic drive_frame(input int len);
      int nb;
      nb = (len == 0) ? 1 : (len + BB - 1) / BB;
      for (int b = 0; b < nb; b++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sof   = (b == 0);
         in_eof   = (b == nb - 1);
         for (int k = 0; k < BB; k++) begin
            in_data[8*BB-1-8*k -: 8] = (b*BB + k < len) ? pay[b*BB + k] : 8'hC3;
         end
         in_nbytes = (b == nb - 1) ? CW'(len - BB*(nb-1)) : CW'(BB);
         if (b == 0) begin
            hdr_l3 = t_l3; hdr_v6_frag = t_v6f; hdr_frag_off = t_off;
            hdr_more_frag = t_mf; hdr_proto = t_proto; hdr_udp_csum = t_ucs;
            hdr_ip_id = t_id; hash_in = t_hash;
         end else begin
            hdr_l3 = ~t_l3; hdr_v6_frag = ~t_v6f; hdr_frag_off = ~t_off;
            hdr_more_frag = ~t_mf; hdr_proto = 8'hAA; hdr_udp_csum = ~t_ucs;
            hdr_ip_id = ~t_id; hash_in = ~t_hash;
         end
      end
      @(posedge clk);
      #1;
   endtask

   task automatic go_idle();
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
   endtask

   typedef struct packed {
      logic [1:0]  l3;
      logic        v6f;
      logic [12:0] off;
      logic        mf;
      logic [7:0]  proto;
      logic [15:0] ucs;
      logic [7:0]  len;
      logic [7:0]  seed;
      logic        hsel;
      logic        en;
      logic        eudpv;
      logic        eudpcs;
      logic        el4cs;
      logic [1:0]  ekind;   // 0 zero checksum, 1 payload sum, 2 hash
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{2'd2,1'b0,13'd0,  1'b0,8'd6, 16'h0000,8'd9, 8'd1,  1'b0,1'b1,1'b0,1'b0,1'b1,2'd0}, // R2 v6 tcp
      '{2'd2,1'b0,13'd0,  1'b0,8'd17,16'h0101,8'd8, 8'd2,  1'b0,1'b1,1'b0,1'b0,1'b0,2'd0}, // R2 v6 udp
      '{2'd2,1'b1,13'd0,  1'b0,8'd6, 16'h0000,8'd6, 8'd3,  1'b0,1'b1,1'b0,1'b0,1'b0,2'd0}, // R2 v6 frag tcp
      '{2'd0,1'b0,13'd0,  1'b0,8'd6, 16'h0000,8'd5, 8'd4,  1'b0,1'b1,1'b0,1'b0,1'b0,2'd0}, // R2 other
      '{2'd1,1'b0,13'd0,  1'b0,8'd17,16'h1111,8'd12,8'd5,  1'b0,1'b1,1'b0,1'b1,1'b1,2'd0}, // R3 udp
      '{2'd1,1'b0,13'd0,  1'b0,8'd6, 16'h0000,8'd10,8'd6,  1'b0,1'b1,1'b0,1'b0,1'b1,2'd0}, // R3 tcp
      '{2'd1,1'b0,13'd0,  1'b0,8'd1, 16'h0000,8'd4, 8'd7,  1'b0,1'b1,1'b0,1'b0,1'b0,2'd0}, // R3 icmp
      '{2'd1,1'b0,13'd100,1'b1,8'd17,16'h2222,8'd16,8'd8,  1'b0,1'b1,1'b0,1'b1,1'b0,2'd1}, // R4 middle
      '{2'd1,1'b0,13'd200,1'b0,8'd17,16'h0000,8'd7, 8'd9,  1'b0,1'b1,1'b0,1'b1,1'b0,2'd1}, // R4 last, odd
      '{2'd1,1'b0,13'd0,  1'b1,8'd17,16'h1234,8'd13,8'd10, 1'b0,1'b1,1'b1,1'b1,1'b0,2'd1}, // R5 udpv
      '{2'd1,1'b0,13'd0,  1'b1,8'd17,16'h0000,8'd8, 8'd11, 1'b0,1'b1,1'b0,1'b1,1'b0,2'd1}, // R5 zero field
      '{2'd1,1'b0,13'd0,  1'b1,8'd6, 16'h7777,8'd5, 8'd12, 1'b0,1'b1,1'b0,1'b1,1'b0,2'd1}, // R5 tcp first
      '{2'd1,1'b0,13'd0,  1'b1,8'd17,16'h1234,8'd8, 8'd13, 1'b1,1'b1,1'b0,1'b0,1'b0,2'd2}, // R10 hsel
      '{2'd1,1'b0,13'd50, 1'b1,8'd17,16'h0000,8'd8, 8'd14, 1'b0,1'b0,1'b0,1'b0,1'b0,2'd2}, // R10 en off
      '{2'd1,1'b0,13'd0,  1'b0,8'd17,16'h0000,8'd8, 8'd15, 1'b1,1'b1,1'b0,1'b1,1'b1,2'd2}, // R1/R3 hsel
      '{2'd1,1'b0,13'd0,  1'b1,8'd17,16'h0005,8'd0, 8'd16, 1'b0,1'b1,1'b1,1'b1,1'b0,2'd1}, // R6 empty
      '{2'd1,1'b0,13'd8,  1'b0,8'd17,16'h0000,8'd1, 8'd17, 1'b0,1'b1,1'b0,1'b1,1'b0,2'd1}, // R6 one byte
      '{2'd1,1'b0,13'd8,  1'b1,8'd17,16'h0000,8'd11,8'hFF, 1'b0,1'b1,1'b0,1'b1,1'b0,2'd1}  // R6 carries
   };

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", n_run, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] s_a;
      logic [15:0] s_b;
      logic [31:0] exp_w;
      // R9: reset state
      repeat (3) @(posedge clk);
      #1;
      chk(out_valid == 1'b0, "R9 out_valid in reset", 32'(out_valid), 32'd0);
      chk(out_desc_word == 32'd0 && {out_udpv, out_udpcs, out_l4cs} == 3'b000,
          "R9 outputs in reset", out_desc_word, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         fill(int'(VECS[v].len), VECS[v].seed);
         t_l3 = VECS[v].l3; t_v6f = VECS[v].v6f; t_off = VECS[v].off; t_mf = VECS[v].mf;
         t_proto = VECS[v].proto; t_ucs = VECS[v].ucs;
         t_id = 16'h1200 + 16'(v); t_hash = 32'hC0DE0000 + 32'(v);
         cfg_hash_sel = VECS[v].hsel;
         cfg_pay_csum_en = VECS[v].en;
         drive_frame(int'(VECS[v].len));
         case (VECS[v].ekind)
            2'd0:    exp_w = {t_id, 16'h0000};
            2'd1:    exp_w = {t_id, ref_sum(int'(VECS[v].len))};
            default: exp_w = t_hash;
         endcase
         chk(out_valid == 1'b1, $sformatf("R8 strobe vec %0d", v), 32'(out_valid), 32'd1);
         chk(out_desc_word == exp_w, $sformatf("R1 R6 R11 word vec %0d", v), out_desc_word, exp_w);
         chk({out_udpv, out_udpcs, out_l4cs} == {VECS[v].eudpv, VECS[v].eudpcs, VECS[v].el4cs},
             $sformatf("R2 R3 R4 R5 R10 flags vec %0d", v),
             32'({out_udpv, out_udpcs, out_l4cs}),
             32'({VECS[v].eudpv, VECS[v].eudpcs, VECS[v].el4cs}));
         go_idle();
         @(posedge clk);
         #1;
         chk(out_valid == 1'b0, $sformatf("R8 strobe drops vec %0d", v), 32'(out_valid), 32'd0);
      end

      // R7: two fragments whose sums combine to 0xFFFF
      cfg_hash_sel = 1'b0; cfg_pay_csum_en = 1'b1;
      t_l3 = 2'd1; t_v6f = 1'b0; t_proto = 8'd17; t_ucs = 16'h4321;
      t_id = 16'h7A7A; t_hash = 32'h0;
      fill(16, 8'd40);
      s_a = ref_sum(16);
      t_off = 13'd0; t_mf = 1'b1;
      drive_frame(16);
      chk(out_desc_word[15:0] == s_a, "R7 first fragment sum", 32'(out_desc_word[15:0]), 32'(s_a));
      s_a = out_desc_word[15:0];
      go_idle();
      fill(10, 8'd41);
      pay[8] = 8'h00; pay[9] = 8'h00;
      s_b = ~ref_add(s_a, ref_sum(10));
      pay[8] = s_b[15:8]; pay[9] = s_b[7:0];
      t_off = 13'd2; t_mf = 1'b0;
      drive_frame(10);
      s_b = out_desc_word[15:0];
      chk(ref_add(s_a, s_b) == 16'hFFFF, "R7 combined fragments", 32'(ref_add(s_a, s_b)), 32'hFFFF);
      go_idle();

      // R8: single-beat frames on consecutive cycles
      t_off = 13'd0; t_mf = 1'b1; t_ucs = 16'h0001;
      fill(4, 8'd50);
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_nbytes = CW'(4);
      in_data = {pay[0], pay[1], pay[2], pay[3]};
      hdr_l3 = 2'd1; hdr_frag_off = 13'd0; hdr_more_frag = 1'b1; hdr_proto = 8'd17;
      hdr_udp_csum = 16'h0001; hdr_ip_id = 16'h0A0A;
      @(posedge clk);
      @(negedge clk);
      in_data = 32'hFFFF_0001;
      @(posedge clk);
      #1;
      chk(out_valid == 1'b1, "R8 back-to-back second strobe", 32'(out_valid), 32'd1);
      chk(out_desc_word == {16'h0A0A, 16'h0001}, "R6 R11 back-to-back restart sum",
          out_desc_word, {16'h0A0A, 16'h0001});
      go_idle();

      // R11: a new sof abandons a partial frame
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0; in_data = 32'h1234_5678;
      hdr_frag_off = 13'd3; hdr_more_frag = 1'b0;
      @(negedge clk);
      in_sof = 1'b1; in_eof = 1'b1; in_nbytes = CW'(2); in_data = 32'h0042_9999;
      hdr_ip_id = 16'hBEEF;
      @(posedge clk);
      #1;
      chk(out_desc_word == {16'hBEEF, 16'h0042}, "R11 sof discards partial sum",
          out_desc_word, {16'hBEEF, 16'h0042});
      go_idle();

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule